// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit turns an indexed-mode postbyte and its optional extension bytes into a 16-bit effective address for an 8/16-bit microcontroller core. The caller presents the postbyte, up to two extension bytes, the current index registers (X, Y, stack pointer), the address of the byte that follows the whole instruction, and the two 8-bit accumulators. It pulses `start` for one cycle. The unit then selects a base register, forms an offset, adds the two, and returns the address with a one-cycle `done` strobe. The 16-bit accumulator D is the pair {A, B}.

The unit supports several offset forms:
- signed constant offsets of 5, 9 or 16 bits;
- unsigned accumulator offsets taken from A, B or D;
- automatic pre/post increment or decrement of the base by 1 to 8, with the new base value handed back on a write-back port.

In the two memory-indirect forms, base plus offset names a location that holds a big-endian 16-bit pointer. The unit reads that pointer through a synchronous byte-wide memory port, and the pointer becomes the result.

Postbyte layout (bit 7 on the left):
- `rr0nnnnn`: 5-bit signed offset.
- `rr1pnnnn`: auto-modify.
- `111rr0zs`: 9-bit (z=0, s is the sign bit) or 16-bit (z=1, s=0) offset.
- `111rr011`: 16-bit-offset indirect.
- `111rr1aa`: accumulator offset, with aa = 00 for A, 01 for B and 10 for D.
- `111rr111`: D-offset indirect.

The field rr picks the base: 00 X, 01 Y, 10 SP, 11 PC. The `111` prefix takes priority over the auto-modify form. As a result, auto-modify can never select PC, and PC is never written back.

Top module: `idx_ea_unit`

## Requirements
- R1: While reset is active and after its release with no request, `done`, `wb_en` and `mem_rd` are 0 and `ea` is 0x0000.
- R2: Postbyte `rr0nnnnn` yields base + sign-extended nnnnn, with `done` high exactly one cycle after the `start` cycle and low the cycle after that when no new request arrives.
- R3: `111rr0zs` adds a signed offset: {s, ext_hi} sign-extended when z=0, {ext_hi, ext_lo} when z=1 and s=0. Offset 0xFFF8 acts as -8. All sums wrap modulo 2^16.
- R4: `111rr1aa` adds A (aa=00), B (aa=01) or D={A,B} (aa=10) as an unsigned value, so B=0xFF adds 255.
- R5: `rr1pnnnn` changes the base by nnnn+1 when nnnn is 0 to 7, and by nnnn-16 when nnnn is 8 to 15. With p=0 (pre) the result is the changed base. With p=1 (post) the result is the old base.
- R6: `wb_en` pulses together with `done` only for auto-modify postbytes. It carries `wb_sel` = rr and `wb_data` = changed base, and `wb_sel` is never 11 (PC).
- R7: When rr=11, the base is the `pc_next` input, the address of the byte after the complete instruction.
- R8: For `111rr011` and `111rr111`, the unit reads the high byte at base+offset and then the low byte at base+offset+1, on two consecutive `mem_rd` cycles. `ea` becomes {high, low}, and `done` rises four cycles after the `start` cycle, with no write-back.
- R9: A `start` that arrives while a pointer fetch is in progress is ignored. It does not change the result and produces no extra `done`.
- R10: The example postbytes decode as follows: 0x00 is 0,X; 0x12 is -14,X; 0xB1 is post-increment SP by 2; 0xED is B,Y; 0xEE is D,Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; inputs below are sampled in this cycle |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext_hi | input | 8 | First extension byte |
| ext_lo | input | 8 | Second extension byte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| pc_next | input | 16 | Address of byte following the whole instruction |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| ea | output | 16 | Effective address, valid with `done` and held afterwards |
| done | output | 1 | Result strobe |
| wb_en | output | 1 | Base register write-back enable |
| wb_sel | output | 2 | Base register to write (rr encoding) |
| wb_data | output | 16 | New base value |

## Verification
The assertions assume that the memory returns data exactly one cycle after each `mem_rd` cycle, and that `start` is a clean single-cycle level sampled on the clock. They assume nothing about the postbyte value, because every encoding decodes to some mode. The stimulus drives every input half a period away from the sampling edge. It draws postbytes and register values at random over the full 8- and 16-bit ranges, so that every mode, base and wrap case occurs. A bench memory with a fixed, address-dependent content answers reads with the required one-cycle latency. Extra `start` pulses are issued only while a pointer fetch is in flight, which is the single case where they must be ignored.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [1:0] {
    BR_X  = 2'b00,
    BR_Y  = 2'b01,
    BR_SP = 2'b10,
    BR_PC = 2'b11
  } base_e;

  typedef enum logic [2:0] {
    OK_C5, OK_C9, OK_C16, OK_ACC_A, OK_ACC_B, OK_ACC_D, OK_AUTO
  } ofs_e;

  typedef struct packed {
    base_e      base;
    ofs_e       kind;
    logic       indirect;
    logic       post;
    logic [3:0] step;
  } xdec_t;

endpackage

// File: rtl/idx_postbyte_decode.sv
module idx_postbyte_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  output xdec_t      dec
);

  always_comb begin
    dec.base     = base_e'(pb[7:6]);
    dec.kind     = OK_C5;
    dec.indirect = 1'b0;
    dec.post     = pb[4];
    dec.step     = pb[3:0];
    if (pb[7:5] == 3'b111) begin
      dec.base = base_e'(pb[4:3]);
      if (!pb[2]) begin
        if (pb[1:0] == 2'b11) begin
          dec.kind     = OK_C16;
          dec.indirect = 1'b1;
        end else if (!pb[1]) begin
          dec.kind = OK_C9;
        end else begin
          dec.kind = OK_C16;
        end
      end else begin
        unique case (pb[1:0])
          2'b00: dec.kind = OK_ACC_A;
          2'b01: dec.kind = OK_ACC_B;
          2'b10: dec.kind = OK_ACC_D;
          default: begin
            dec.kind     = OK_ACC_D;
            dec.indirect = 1'b1;
          end
        endcase
      end
    end else if (pb[5]) begin
      dec.kind = OK_AUTO;
    end
  end

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  xdec_t               dec,
  input  logic [4:0]          ofs5,
  input  logic [DATA_W-1:0]   ext_hi,
  input  logic [DATA_W-1:0]   ext_lo,
  input  logic [ADDR_W-1:0]   reg_x,
  input  logic [ADDR_W-1:0]   reg_y,
  input  logic [ADDR_W-1:0]   reg_sp,
  input  logic [ADDR_W-1:0]   pc_next,
  input  logic [DATA_W-1:0]   acc_a,
  input  logic [DATA_W-1:0]   acc_b,
  output logic [ADDR_W-1:0]   addr,
  output logic                wb_req,
  output logic [ADDR_W-1:0]   wb_val
);

  logic [ADDR_W-1:0] base_v;
  logic [ADDR_W-1:0] ofs_v;
  logic [ADDR_W-1:0] sum_v;

  always_comb begin
    unique case (dec.base)
      BR_X:    base_v = reg_x;
      BR_Y:    base_v = reg_y;
      BR_SP:   base_v = reg_sp;
      default: base_v = pc_next;
    endcase
  end

  always_comb begin
    unique case (dec.kind)
      OK_C5:    ofs_v = {{(ADDR_W-5){ofs5[4]}}, ofs5};
      OK_C9:    ofs_v = {{(ADDR_W-DATA_W-1){ofs5[0]}}, ofs5[0], ext_hi};
      OK_C16:   ofs_v = {ext_hi, ext_lo};
      OK_ACC_A: ofs_v = {{DATA_W{1'b0}}, acc_a};
      OK_ACC_B: ofs_v = {{DATA_W{1'b0}}, acc_b};
      OK_ACC_D: ofs_v = {acc_a, acc_b};
      default:  ofs_v = dec.step[3] ? {{(ADDR_W-4){1'b1}}, dec.step}
                                    : {{(ADDR_W-4){1'b0}}, dec.step} + 1'b1;
    endcase
  end

  assign sum_v  = base_v + ofs_v;
  assign wb_req = (dec.kind == OK_AUTO) && !dec.indirect;
  assign wb_val = sum_v;
  assign addr   = (wb_req && dec.post) ? base_v : sum_v;

endmodule

// File: rtl/idx_ptr_fetch.sv
module idx_ptr_fetch #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fin,
  output logic [ADDR_W-1:0] ptr_val
);

  typedef enum logic [1:0] {PF_IDLE, PF_HI, PF_LO, PF_END} pf_e;

  pf_e               st_q, st_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] hi_q;
  logic              addr_en, hi_en;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      PF_IDLE: if (go) st_n = PF_HI;
      PF_HI:   st_n = PF_LO;
      PF_LO:   st_n = PF_END;
      default: st_n = PF_IDLE;
    endcase
  end

  assign addr_en = (st_q == PF_IDLE) && go;
  assign hi_en   = (st_q == PF_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PF_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
    end else begin
      st_q <= st_n;
      if (addr_en) addr_q <= ptr_addr;
      if (hi_en)   hi_q   <= mem_rdata;
    end
  end

  assign busy     = (st_q != PF_IDLE);
  assign mem_rd   = (st_q == PF_HI) || (st_q == PF_LO);
  assign mem_addr = (st_q == PF_LO) ? addr_q + 1'b1 : addr_q;
  assign fin      = (st_q == PF_END);
  assign ptr_val  = {hi_q, mem_rdata};

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        postbyte,
  input  logic [DATA_W-1:0] ext_hi,
  input  logic [DATA_W-1:0] ext_lo,
  input  logic [ADDR_W-1:0] reg_x,
  input  logic [ADDR_W-1:0] reg_y,
  input  logic [ADDR_W-1:0] reg_sp,
  input  logic [ADDR_W-1:0] pc_next,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] ea,
  output logic              done,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_data
);

  xdec_t             dec;
  logic [ADDR_W-1:0] addr_c, wb_val_c, ptr_val;
  logic              wb_req_c, busy, fin;
  logic              accept, go_ptr, direct_ok;

  idx_postbyte_decode u_dec (
    .pb  (postbyte),
    .dec (dec)
  );

  idx_addr_calc #(.DATA_W(DATA_W)) u_calc (
    .dec     (dec),
    .ofs5    (postbyte[4:0]),
    .ext_hi  (ext_hi),
    .ext_lo  (ext_lo),
    .reg_x   (reg_x),
    .reg_y   (reg_y),
    .reg_sp  (reg_sp),
    .pc_next (pc_next),
    .acc_a   (acc_a),
    .acc_b   (acc_b),
    .addr    (addr_c),
    .wb_req  (wb_req_c),
    .wb_val  (wb_val_c)
  );

  assign accept    = start && !busy;
  assign go_ptr    = accept && dec.indirect;
  assign direct_ok = accept && !dec.indirect;

  idx_ptr_fetch #(.DATA_W(DATA_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_ptr),
    .ptr_addr  (addr_c),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .fin       (fin),
    .ptr_val   (ptr_val)
  );

  logic [ADDR_W-1:0] ea_n;
  logic              done_n, wb_en_n, ea_en, wbd_en;

  always_comb begin
    done_n  = direct_ok || fin;
    wb_en_n = direct_ok && wb_req_c;
    ea_en   = done_n;
    wbd_en  = direct_ok;
    ea_n    = fin ? ptr_val : addr_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea      <= '0;
      done    <= 1'b0;
      wb_en   <= 1'b0;
      wb_sel  <= 2'b00;
      wb_data <= '0;
    end else begin
      done  <= done_n;
      wb_en <= wb_en_n;
      if (ea_en) ea <= ea_n;
      if (wbd_en) begin
        wb_sel  <= dec.base;
        wb_data <= wb_val_c;
      end
    end
  end

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              wb_en,
  input logic [1:0]        wb_sel
);

  // R8
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(mem_rd)) |=> (mem_rd && mem_addr == $past(mem_addr) + 1'b1));

  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done);

  // R8
  rd_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |=> done);

  // R6
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R6
  wb_not_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_sel != 2'b11));

endmodule

bind idx_ea_unit idx_ea_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .done     (done),
  .wb_en    (wb_en),
  .wb_sel   (wb_sel)
);

// File: tb/sim_idx_ea_unit.sv
module sim_idx_ea_unit;

  logic        clk, rst_n, start;
  logic [7:0]  postbyte, ext_hi, ext_lo, acc_a, acc_b, mem_rdata;
  logic [15:0] reg_x, reg_y, reg_sp, pc_next, mem_addr, ea, wb_data;
  logic        mem_rd, done, wb_en;
  logic [1:0]  wb_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  idx_ea_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .ext_hi(ext_hi), .ext_lo(ext_lo), .reg_x(reg_x), .reg_y(reg_y),
    .reg_sp(reg_sp), .pc_next(pc_next), .acc_a(acc_a), .acc_b(acc_b),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ea(ea), .done(done), .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_model(
    input  logic [7:0]  pb, input logic [15:0] x, y, sp, pc,
    input  logic [7:0]  a, b, e1, e2,
    output logic [15:0] e, output logic w, output logic [1:0] ws,
    output logic [15:0] wd, output logic ind);
    logic [1:0]  r;
    logic [15:0] bv, off, nb;
    int          amt;
    w = 0; ws = 0; wd = 0; ind = 0; off = 0;
    r = (pb[7:5] == 3'b111) ? pb[4:3] : pb[7:6];
    case (r)
      2'd0: bv = x;
      2'd1: bv = y;
      2'd2: bv = sp;
      default: bv = pc;
    endcase
    if (pb[7:5] == 3'b111) begin
      if (pb[2] == 1'b0) begin
        if (pb[1] == 1'b0) off = {{7{pb[0]}}, pb[0], e1};
        else begin off = {e1, e2}; ind = pb[0]; end
      end else begin
        case (pb[1:0])
          2'd0: off = {8'h00, a};
          2'd1: off = {8'h00, b};
          default: begin off = {a, b}; ind = (pb[1:0] == 2'd3); end
        endcase
      end
      e = bv + off;
      if (ind) e = {mem_byte(e), mem_byte(e + 16'd1)};
    end else if (pb[5]) begin
      amt = int'(pb[3:0]);
      amt = (amt < 8) ? amt + 1 : amt - 16;
      nb = bv + 16'(amt);
      e = pb[4] ? bv : nb;
      w = 1; ws = r; wd = nb;
    end else begin
      e = bv + {{11{pb[4]}}, pb[4:0]};
    end
  endfunction

  task automatic run_op(input string tag, input logic [7:0] pb,
                        input logic [15:0] x, y, sp, pc,
                        input logic [7:0] a, b, e1, e2);
    logic [15:0] e, wd; logic w, ind; logic [1:0] ws;
    ref_model(pb, x, y, sp, pc, a, b, e1, e2, e, w, ws, wd, ind);
    postbyte = pb; reg_x = x; reg_y = y; reg_sp = sp; pc_next = pc;
    acc_a = a; acc_b = b; ext_hi = e1; ext_lo = e2; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (ind) begin
      for (int k = 0; k < 3; k++) begin
        chk({tag, " R8 done early"}, 16'(done), 16'd0);
        // R9: a stray request during the fetch must be ignored
        start = (k == 0); postbyte = 8'h00;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
      end
    end
    chk({tag, " done"}, 16'(done), 16'd1);
    chk({tag, " ea"}, ea, e);
    chk({tag, " wb_en"}, 16'(wb_en), 16'(w));
    if (w) begin
      chk({tag, " R6 wb_sel"}, 16'(wb_sel), 16'(ws));
      chk({tag, " R6 wb_data"}, wb_data, wd);
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " R2 done drops, R9 no extra done"}, 16'(done), 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; postbyte = 0; ext_hi = 0; ext_lo = 0;
    reg_x = 0; reg_y = 0; reg_sp = 0; pc_next = 0; acc_a = 0; acc_b = 0;
    mem_rdata = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 16'(done), 16'd0);
    chk("R1 ea in reset", ea, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 done idle", 16'(done), 16'd0);
    chk("R1 wb_en idle", 16'(wb_en), 16'd0);
    chk("R1 mem_rd idle", 16'(mem_rd), 16'd0);

    // R10 examples with values fixed by hand
    run_op("R10 0,X", 8'h00, 16'h2000, 16'h1000, 16'h3FFE, 16'h4000, 8'h12, 8'hFF, 8'h00, 8'h00);
    chk("R10 0,X value", ea, 16'h2000);
    run_op("R10 -14,X", 8'h12, 16'h2000, 16'h1000, 16'h3FFE, 16'h4000, 8'h12, 8'hFF, 8'h00, 8'h00);
    chk("R10 -14,X value", ea, 16'h1FF2);
    run_op("R10 SP post+2", 8'hB1, 16'h2000, 16'h1000, 16'h3FFE, 16'h4000, 8'h12, 8'hFF, 8'h00, 8'h00);
    chk("R10 R5 post ea", ea, 16'h3FFE);
    chk("R10 R5 post wb", wb_data, 16'h4000);
    run_op("R10 B,Y", 8'hED, 16'h2000, 16'h1000, 16'h3FFE, 16'h4000, 8'h12, 8'hFF, 8'h00, 8'h00);
    chk("R10 R4 B,Y value", ea, 16'h10FF);
    run_op("R10 D,Y", 8'hEE, 16'h2000, 16'h1000, 16'h3FFE, 16'h4000, 8'h12, 8'h34, 8'h00, 8'h00);
    chk("R10 R4 D,Y value", ea, 16'h2234);
    // R3: 0xFFF8 as -8, and wrap
    run_op("R3 16b neg", 8'hE2, 16'h2000, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'hFF, 8'hF8);
    chk("R3 FFF8 value", ea, 16'h1FF8);
    run_op("R3 wrap", 8'h0F, 16'hFFFF, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    chk("R3 wrap value", ea, 16'h000E);
    // R5 pre-decrement by 1
    run_op("R5 pre-dec", 8'h2F, 16'h2000, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    chk("R5 pre-dec ea", ea, 16'h1FFF);
    chk("R5 pre-dec wb", wb_data, 16'h1FFF);
    // R7 PC base
    run_op("R7 pc", 8'hC3, 16'h0, 16'h0, 16'h0, 16'h1005, 8'h0, 8'h0, 8'h0, 8'h0);
    chk("R7 pc value", ea, 16'h1008);
    // R8 indirect
    run_op("R8 ind16", 8'hE3, 16'h1000, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h00, 8'h10);
    chk("R8 ind16 value", ea, {mem_byte(16'h1010), mem_byte(16'h1011)});
    run_op("R8 indD", 8'hFF, 16'h0, 16'h0, 16'h0, 16'hFFFF, 8'h00, 8'h00, 8'h0, 8'h0);
    chk("R8 indD wrap", ea, {mem_byte(16'hFFFF), mem_byte(16'h0000)});

    for (int i = 0; i < 400; i++) begin
      run_op("R2-R9 rand", 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule